// File: doc/BRIEF.md
# Arithmetic Status Flag and Processor Status Word Unit

This block performs a 16-bit addition or subtraction and derives the conditional status flags from it. The flags are carry or borrow, nibble carry, low-byte parity, zero, sign and signed overflow. On a qualified clock edge the block stores them at fixed positions of a 16-bit processor status word (PSW). The same register also holds three control bits: direction, interrupt enable and single-step trap. These bits are loaded through a separate write port and are never touched by arithmetic.

Chained multi-word arithmetic is supported. When carry chaining is selected, the stored carry flag enters the adder as carry-in for an addition or as borrow-in for a subtraction. The interrupt-enable bit of the PSW is also brought out as a level for the interrupt controller.

Top module: `psw_flag_unit`

## Requirements
- R1: `result` equals (a + b + cin) mod 2^16 when `op_sub`=0 and (a - b - cin) mod 2^16 when `op_sub`=1, combinationally; cin is 0 unless R7 applies.
- R2: The sign flag (PSW bit 7) takes result bit 15, and the zero flag (bit 6) is 1 exactly when the result is 0000h; for example, 60FFh + 9F01h stores PSW 0055h when the control bits are clear.
- R3: The parity flag (bit 2) is 1 when result bits 7..0 hold an even number of ones.
- R4: The carry flag (bit 0) is 1 on a carry out of bit 15 for an addition, or on a borrow (a < b + cin) for a subtraction.
- R5: The auxiliary flag (bit 4) is 1 on a carry out of bit 3 for an addition, or on a borrow from the low nibble for a subtraction.
- R6: The overflow flag (bit 11) is 1 when the true signed result lies outside -32768..32767.
- R7: With `op_cin_en`=1, the stored carry flag is used as cin in R1, R4, R5 and R6.
- R8: The arithmetic flags change only on a rising edge where `flag_we` and `op_valid` are both 1; otherwise they hold.
- R9: When `ctl_we`=1, bits 10 (direction), 9 (interrupt enable) and 8 (trap) are loaded from the same positions of `ctl_din`. Arithmetic never alters them.
- R10: PSW bits 1, 3, 5 and 12..15 always read 0, whatever is written.
- R11: `int_enable` equals PSW bit 9.
- R12: After reset the PSW reads 0000h.
- R13: An arithmetic flag update and a control load in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operands and operation are valid this cycle |
| flag_we | input | 1 | Request to store the arithmetic flags |
| op_sub | input | 1 | 0 add, 1 subtract |
| op_cin_en | input | 1 | Use the stored carry flag as carry or borrow in |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| result | output | 16 | Arithmetic result |
| ctl_we | input | 1 | Load the control bits |
| ctl_din | input | 16 | Control bit values, at PSW positions |
| psw | output | 16 | Processor status word |
| int_enable | output | 1 | Maskable interrupts enabled |

## Verification
An arithmetic flag update and a control-bit load can land on the same clock edge and write disjoint fields of one register. The bench overlaps them by pseudo-randomly asserting `ctl_we` with random `ctl_din` during operand sweeps. A reference PSW in the bench applies both effects independently. Each field of the stored word is then compared against that reference, so a load that drops the other side's update shows up in the field it lost.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W  = 16;
  localparam int POS_CF = 0;
  localparam int POS_PF = 2;
  localparam int POS_AF = 4;
  localparam int POS_ZF = 6;
  localparam int POS_SF = 7;
  localparam int POS_TF = 8;
  localparam int POS_IF = 9;
  localparam int POS_DF = 10;
  localparam int POS_OF = 11;

  localparam logic [PSW_W-1:0] ARITH_MASK = (PSW_W'(1) << POS_CF) | (PSW_W'(1) << POS_PF) |
                                            (PSW_W'(1) << POS_AF) | (PSW_W'(1) << POS_ZF) |
                                            (PSW_W'(1) << POS_SF) | (PSW_W'(1) << POS_OF);
  localparam logic [PSW_W-1:0] CTL_MASK   = (PSW_W'(1) << POS_TF) | (PSW_W'(1) << POS_IF) |
                                            (PSW_W'(1) << POS_DF);
  localparam logic [PSW_W-1:0] USED_MASK  = ARITH_MASK | CTL_MASK;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } arith_flags_t;
endpackage

// File: rtl/psw_addsub.sv
module psw_addsub #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              cin_req,
  output logic [DATA_W-1:0] sum,
  output logic              carry_flag,
  output logic              aux_flag,
  output logic              ovf_flag
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              c_raw;
  logic              c_top;
  logic [NIB_W:0]    nib_sum;

  always_comb begin
    b_eff          = sub ? ~b : b;
    c_raw          = sub ? ~cin_req : cin_req;
    {c_top, sum}   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_raw};
    nib_sum        = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_raw};
    carry_flag     = c_top ^ sub;
    aux_flag       = nib_sum[NIB_W] ^ sub;
    ovf_flag       = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/psw_result_flags.sv
module psw_result_flags #(
  parameter int DATA_W = 16,
  parameter int PAR_W  = 8
) (
  input  logic [DATA_W-1:0] res,
  output logic              sign_flag,
  output logic              zero_flag,
  output logic              parity_flag
);
  logic [PAR_W:0] par_chain;

  assign par_chain[0] = 1'b1;
  for (genvar g = 0; g < PAR_W; g++) begin : g_par
    assign par_chain[g+1] = par_chain[g] ^ res[g];
  end

  always_comb begin
    sign_flag   = res[DATA_W-1];
    zero_flag   = (res == '0);
    parity_flag = par_chain[PAR_W];
  end
endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arith_we,
  input  arith_flags_t     arith_in,
  input  logic             ctl_we,
  input  logic [PSW_W-1:0] ctl_din,
  output logic [PSW_W-1:0] psw_q
);
  logic [PSW_W-1:0] psw_d;
  logic             reg_en;

  always_comb begin
    psw_d = psw_q;
    if (arith_we) begin
      psw_d[POS_CF] = arith_in.cf;
      psw_d[POS_PF] = arith_in.pf;
      psw_d[POS_AF] = arith_in.af;
      psw_d[POS_ZF] = arith_in.zf;
      psw_d[POS_SF] = arith_in.sf;
      psw_d[POS_OF] = arith_in.of;
    end
    if (ctl_we) begin
      psw_d = (psw_d & ~CTL_MASK) | (ctl_din & CTL_MASK);
    end
    psw_d  = psw_d & USED_MASK;
    reg_en = arith_we | ctl_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q <= '0;
    end else if (reg_en) begin
      psw_q <= psw_d;
    end
  end
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              flag_we,
  input  logic              op_sub,
  input  logic              op_cin_en,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  input  logic              ctl_we,
  input  logic [PSW_W-1:0]  ctl_din,
  output logic [PSW_W-1:0]  psw,
  output logic              int_enable
);
  localparam int NIB_W = 4;
  localparam int PAR_W = 8;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s;
  logic                   cin_req;
  logic                   cf_w, af_w, of_w, sf_w, zf_w, pf_w;
  logic                   arith_we;
  arith_flags_t           flags_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_s = rst_pipe[SYNC_STAGES-1];

  assign cin_req = op_cin_en & psw[POS_CF];

  psw_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
    .a          (a),
    .b          (b),
    .sub        (op_sub),
    .cin_req    (cin_req),
    .sum        (result),
    .carry_flag (cf_w),
    .aux_flag   (af_w),
    .ovf_flag   (of_w)
  );

  psw_result_flags #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_resflags (
    .res         (result),
    .sign_flag   (sf_w),
    .zero_flag   (zf_w),
    .parity_flag (pf_w)
  );

  always_comb begin
    flags_w.cf = cf_w;
    flags_w.pf = pf_w;
    flags_w.af = af_w;
    flags_w.zf = zf_w;
    flags_w.sf = sf_w;
    flags_w.of = of_w;
    arith_we   = flag_we & op_valid;
  end

  psw_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_s),
    .arith_we (arith_we),
    .arith_in (flags_w),
    .ctl_we   (ctl_we),
    .ctl_din  (ctl_din),
    .psw_q    (psw)
  );

  assign int_enable = psw[POS_IF];
endmodule

// File: rtl/psw_flag_chk.sv
module psw_flag_chk
  import psw_pkg::*;
(
  input logic              clk,
  input logic              rst_s,
  input logic              op_valid,
  input logic              flag_we,
  input logic [15:0]       result,
  input logic              ctl_we,
  input logic [PSW_W-1:0]  ctl_din,
  input logic [PSW_W-1:0]  psw,
  input logic              int_enable
);
  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (psw & ~USED_MASK) == '0);

  // R8
  arith_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(flag_we && op_valid) |=> (psw & ARITH_MASK) == $past(psw & ARITH_MASK));

  // R9
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !ctl_we |=> $stable(psw & CTL_MASK));

  // R11
  int_enable_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ctl_we |=> int_enable == $past(ctl_din[POS_IF]));

  // R2
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (flag_we && op_valid) |=> psw[POS_ZF] == ($past(result) == 16'h0000));

  // R13
  both_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (flag_we && op_valid && ctl_we) |=>
      ((psw & CTL_MASK) == $past(ctl_din & CTL_MASK)) && (psw[POS_SF] == $past(result[15])));
endmodule

bind psw_flag_unit psw_flag_chk u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .op_valid   (op_valid),
  .flag_we    (flag_we),
  .result     (result),
  .ctl_we     (ctl_we),
  .ctl_din    (ctl_din),
  .psw        (psw),
  .int_enable (int_enable)
);

// File: tb/sim_psw_flag_unit.sv
module sim_psw_flag_unit;
  logic        clk;
  logic        rst_n;
  logic        op_valid, flag_we, op_sub, op_cin_en, ctl_we;
  logic [15:0] a, b, ctl_din;
  logic [15:0] result, psw;
  logic        int_enable;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_psw;
  logic        done = 1'b0;

  psw_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .flag_we(flag_we),
    .op_sub(op_sub), .op_cin_en(op_cin_en), .a(a), .b(b), .result(result),
    .ctl_we(ctl_we), .ctl_din(ctl_din), .psw(psw), .int_enable(int_enable)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_psw();
    chk(psw[0] == exp_psw[0], "R4 CF", psw, exp_psw);
    chk(psw[4] == exp_psw[4], "R5 AF", psw, exp_psw);
    chk(psw[11] == exp_psw[11], "R6 OF", psw, exp_psw);
    chk(psw[7:6] == exp_psw[7:6], "R2 SF/ZF", psw, exp_psw);
    chk(psw[2] == exp_psw[2], "R3 PF", psw, exp_psw);
    chk(psw[10:8] == exp_psw[10:8], "R9/R13 control", psw, exp_psw);
    chk((psw & 16'hF02A) == 16'h0, "R10 unused", psw, exp_psw);
    chk(int_enable == exp_psw[9], "R11 int_enable", int_enable, exp_psw[9]);
  endtask

  // Drive one cycle at a negedge, check result, clock, check PSW
  task automatic step(input logic [15:0] ta, input logic [15:0] tb_, input bit sub,
                      input bit cen, input bit fwe, input bit vld,
                      input bit cwe, input logic [15:0] cdin);
    int cin, full, sa, sb, sr, ones;
    logic [15:0] res_e;
    bit cf_e, af_e, of_e, pf_e;
    a = ta; b = tb_; op_sub = sub; op_cin_en = cen;
    flag_we = fwe; op_valid = vld; ctl_we = cwe; ctl_din = cdin;
    cin = (cen && exp_psw[0]) ? 1 : 0;
    sa = (ta >= 16'h8000) ? int'(ta) - 65536 : int'(ta);
    sb = (tb_ >= 16'h8000) ? int'(tb_) - 65536 : int'(tb_);
    if (!sub) begin
      full = int'(ta) + int'(tb_) + cin;
      cf_e = full > 65535;
      af_e = (int'(ta & 16'hF) + int'(tb_ & 16'hF) + cin) > 15;
      sr = sa + sb + cin;
    end else begin
      full = int'(ta) - int'(tb_) - cin;
      cf_e = int'(ta) < int'(tb_) + cin;
      af_e = int'(ta & 16'hF) < int'(tb_ & 16'hF) + cin;
      sr = sa - sb - cin;
    end
    res_e = full[15:0];
    of_e = (sr > 32767) || (sr < -32768);
    ones = 0;
    for (int k = 0; k < 8; k++) ones += res_e[k];
    pf_e = (ones % 2) == 0;
    #2;
    chk(result == res_e, cen ? "R7 result" : "R1 result", result, res_e);
    if (fwe && vld) begin
      exp_psw[0] = cf_e; exp_psw[2] = pf_e; exp_psw[4] = af_e;
      exp_psw[6] = (res_e == 16'h0); exp_psw[7] = res_e[15]; exp_psw[11] = of_e;
    end
    if (cwe) exp_psw[10:8] = cdin[10:8];
    @(posedge clk);
    @(negedge clk);
    check_psw();
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [12];
    logic [15:0] lfsr;
    vals = '{16'h0000, 16'h0001, 16'h000F, 16'h0010, 16'h007F, 16'h00FF,
             16'h60FF, 16'h7FFF, 16'h8000, 16'h9F01, 16'hFFFE, 16'hFFFF};
    rst_n = 1'b0; op_valid = 0; flag_we = 0; op_sub = 0; op_cin_en = 0;
    ctl_we = 0; ctl_din = '0; a = '0; b = '0;
    exp_psw = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(psw == 16'h0000, "R12 reset", psw, 0);
    chk(int_enable == 1'b0, "R12 int_enable", int_enable, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(psw == 16'h0000, "R12 after release", psw, 0);

    // R9/R10/R11: control load with all bits set
    step(16'h0, 16'h0, 0, 0, 0, 0, 1, 16'hFFFF);
    chk(psw == 16'h0700, "R10 write all ones", psw, 16'h0700);
    step(16'h0, 16'h0, 0, 0, 0, 0, 1, 16'h0200);
    chk(int_enable == 1'b1, "R11 IF only", int_enable, 1);
    step(16'h0, 16'h0, 0, 0, 0, 0, 1, 16'h0000);

    // R2 worked example
    step(16'h60FF, 16'h9F01, 0, 0, 1, 1, 0, 16'h0);
    chk(psw == 16'h0055, "R2 example 60FF+9F01", psw, 16'h0055);

    // R8: flags held without both enables
    step(16'h7FFF, 16'h0001, 0, 0, 1, 0, 0, 16'h0);
    chk(psw == 16'h0055, "R8 no valid", psw, 16'h0055);
    step(16'h7FFF, 16'h0001, 0, 0, 0, 1, 0, 16'h0);
    chk(psw == 16'h0055, "R8 no we", psw, 16'h0055);

    // R9: arithmetic leaves control bits
    step(16'h0, 16'h0, 0, 0, 0, 0, 1, 16'h0500);
    step(16'h8000, 16'h0001, 1, 0, 1, 1, 0, 16'h0);
    chk(psw[10:8] == 3'b101, "R9 arith keeps control", psw, 16'h0500);

    // Boundary sweep: R1..R7
    foreach (vals[i]) foreach (vals[j])
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 2; c++)
          step(vals[i], vals[j], s[0], c[0], 1, 1, 0, 16'h0);

    // Pseudo-random mix with overlapping control loads (R13)
    lfsr = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] ra, rb, rc;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; ra = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; rb = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; rc = lfsr;
      step(ra, rb, rc[0], rc[1], rc[2] | rc[3], rc[4] | rc[5], rc[6], {rc[15:11], ra[10:8], rb[7:0]});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule